// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block produces the 13-bit instruction fetch address for a small accumulator CPU. Each cycle the sequencer raises at most one meaningful strobe. The address can advance by one, take a new low byte written by the datapath, jump or call to an 11-bit target carried in the opcode, vector to the interrupt entry, or return to an address saved earlier. The address bits that the opcode or the data byte cannot supply come from a 5-bit upper-address holding register. The sequencer writes that register directly. A low-byte write copies all five of its bits into the address. A jump or call copies only its two page bits, bits 4 and 3.

Return addresses are kept in an eight-entry stack of full 13-bit addresses. The stack is a plain ring: a push past the eighth entry overwrites the oldest one, and a pop from an empty stack reads whatever entry the pointer wraps to. No status is produced for either case. A parameter sets the width of the implemented program memory. When it is smaller than the counter, addresses above the implemented range wrap back to the bottom of memory.

Top module: `paged_pc`

## Requirements
- R1: Reset sets the address to 0000h, clears the holding register and empties the stack (pointer at entry 0).
- R2: An increment strobe adds one to the 13-bit counter, which wraps from 1FFFh to 0000h. The presented address keeps only the low IMPL_ADDR_W bits, so with IMPL_ADDR_W=12 an increment from 0FFFh presents 0000h.
- R3: A low-byte write loads address bits 7:0 from the data byte and bits 12:8 from holding register bits 4:0. The low-byte output always shows address bits 7:0.
- R4: A jump loads address bits 10:0 from the 11-bit target field and bits 12:11 from holding register bits 4:3. Holding register bits 2:0 have no effect on a jump.
- R5: A call jumps exactly as in R4 and pushes the address of the current instruction plus one.
- R6: A return loads the address from the most recently pushed stack entry and moves the stack pointer back by one.
- R7: An interrupt strobe pushes the current address unchanged and loads 0004h, so a later return resumes at the interrupted address.
- R8: The stack is a ring of eight entries. After ten pushes, successive pops return the 10th, 9th, ..., 3rd pushed values and then the 10th and 9th again.
- R9: Pushes and pops leave the holding register unchanged.
- R10: When several strobes are raised together, exactly one acts, in the priority order interrupt, call, jump, return, low-byte write, increment.
- R11: A holding register write takes effect at the next clock edge. A low-byte write or jump in the same cycle uses the old holding register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| incEn | input | 1 | Advance address by one |
| lowWrite | input | 1 | Load low address byte from lowData |
| lowData | input | 8 | New low address byte |
| jumpEn | input | 1 | Jump to jumpField within the selected page |
| callEn | input | 1 | Jump and push return address |
| retEn | input | 1 | Pop address from stack |
| intEn | input | 1 | Push current address and go to interrupt entry |
| jumpField | input | 11 | Target field from the opcode |
| latchWrite | input | 1 | Write upper-address holding register |
| latchData | input | 5 | New holding register value |
| progAddr | output | 13 | Program memory address |
| lowByte | output | 8 | Readable low byte of the address |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default full 13-bit memory width. The other sets IMPL_ADDR_W to 12, the half-size memory, so the wrap of an address above the implemented range can be seen next to the full counter's own wrap from 1FFFh. The stack depth stays at eight, so ten pushes are enough to overwrite entries and let pops wrap through the ring.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_LOW,
    SEL_JUMP,
    SEL_VEC,
    SEL_POP
  } pcSel_e;

  typedef enum logic {
    PUSH_NEXT,
    PUSH_CUR
  } pushSel_e;

  typedef struct packed {
    pcSel_e   sel;
    logic     push;
    logic     pop;
    pushSel_e pushSel;
  } pcStrobes_t;

endpackage

// File: rtl/paged_pc_ctrl.sv
module paged_pc_ctrl
  import paged_pc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incEn,
  input  logic             lowWrite,
  input  logic             jumpEn,
  input  logic             callEn,
  input  logic             retEn,
  input  logic             intEn,
  output pcStrobes_t       strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr
);

  logic [PTR_W-1:0] stackPtr;

  always_comb begin
    strb = '{sel: SEL_HOLD, push: 1'b0, pop: 1'b0, pushSel: PUSH_NEXT};
    if (intEn) begin
      strb.sel     = SEL_VEC;
      strb.push    = 1'b1;
      strb.pushSel = PUSH_CUR;
    end else if (callEn) begin
      strb.sel     = SEL_JUMP;
      strb.push    = 1'b1;
      strb.pushSel = PUSH_NEXT;
    end else if (jumpEn) begin
      strb.sel = SEL_JUMP;
    end else if (retEn) begin
      strb.sel = SEL_POP;
      strb.pop = 1'b1;
    end else if (lowWrite) begin
      strb.sel = SEL_LOW;
    end else if (incEn) begin
      strb.sel = SEL_INC;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr <= '0;
    end else if (strb.push) begin
      stackPtr <= stackPtr + PTR_W'(1);
    end else if (strb.pop) begin
      stackPtr <= stackPtr - PTR_W'(1);
    end
  end

  assign wrPtr = stackPtr;
  assign rdPtr = stackPtr - PTR_W'(1);

  // R10
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.push, strb.pop}));

  // R8
  ptr_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> stackPtr == $past(stackPtr) + PTR_W'(1));

endmodule

// File: rtl/paged_pc_dp.sv
module paged_pc_dp
  import paged_pc_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int FIELD_W     = 11,
  parameter int LATCH_W     = 5,
  parameter int DEPTH       = 8,
  parameter int IMPL_ADDR_W = 13,
  parameter int VECTOR      = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LOW_W  = ADDR_W - LATCH_W,
  localparam int PAGE_W = ADDR_W - FIELD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  pcStrobes_t         strb,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [LOW_W-1:0]   lowData,
  input  logic [FIELD_W-1:0] jumpField,
  input  logic               latchWrite,
  input  logic [LATCH_W-1:0] latchData,
  output logic [ADDR_W-1:0]  progAddr,
  output logic [LOW_W-1:0]   lowByte
);

  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(VECTOR);

  logic [ADDR_W-1:0]  pcReg;
  logic [ADDR_W-1:0]  pcNext;
  logic [ADDR_W-1:0]  pcPlusOne;
  logic [ADDR_W-1:0]  pushVal;
  logic [LATCH_W-1:0] upperLatch;
  logic [ADDR_W-1:0]  stackMem [DEPTH];

  assign pcPlusOne = pcReg + ADDR_W'(1);
  assign pushVal   = (strb.pushSel == PUSH_CUR) ? pcReg : pcPlusOne;

  always_comb begin
    unique case (strb.sel)
      SEL_INC:  pcNext = pcPlusOne;
      SEL_LOW:  pcNext = {upperLatch, lowData};
      SEL_JUMP: pcNext = {upperLatch[LATCH_W-1 -: PAGE_W], jumpField};
      SEL_VEC:  pcNext = VEC_ADDR;
      SEL_POP:  pcNext = stackMem[rdPtr];
      default:  pcNext = pcReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg      <= '0;
      upperLatch <= '0;
    end else begin
      pcReg <= pcNext;
      if (latchWrite) upperLatch <= latchData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stackMem[i] <= '0;
    end else if (strb.push) begin
      stackMem[wrPtr] <= pushVal;
    end
  end

  generate
    if (IMPL_ADDR_W < ADDR_W) begin : g_partial
      assign progAddr = {{(ADDR_W-IMPL_ADDR_W){1'b0}}, pcReg[IMPL_ADDR_W-1:0]};
    end else begin : g_full
      assign progAddr = pcReg;
    end
  endgenerate

  assign lowByte = pcReg[LOW_W-1:0];

  // R4
  jump_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_JUMP) |=> pcReg[FIELD_W-1:0] == $past(jumpField) &&
      pcReg[ADDR_W-1:FIELD_W] == $past(upperLatch[LATCH_W-1 -: PAGE_W]));

  // R9
  latch_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.push || strb.pop) && !latchWrite) |=> $stable(upperLatch));

  // R6
  pop_loads_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> pcReg == $past(stackMem[rdPtr]));

endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import paged_pc_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int FIELD_W     = 11,
  parameter int LATCH_W     = 5,
  parameter int DEPTH       = 8,
  parameter int IMPL_ADDR_W = 13,
  parameter int VECTOR      = 4,
  localparam int LOW_W = ADDR_W - LATCH_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               incEn,
  input  logic               lowWrite,
  input  logic [LOW_W-1:0]   lowData,
  input  logic               jumpEn,
  input  logic               callEn,
  input  logic               retEn,
  input  logic               intEn,
  input  logic [FIELD_W-1:0] jumpField,
  input  logic               latchWrite,
  input  logic [LATCH_W-1:0] latchData,
  output logic [ADDR_W-1:0]  progAddr,
  output logic [LOW_W-1:0]   lowByte
);

  pcStrobes_t       strb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  paged_pc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .incEn(incEn), .lowWrite(lowWrite),
    .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn), .intEn(intEn),
    .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  paged_pc_dp #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .LATCH_W(LATCH_W), .DEPTH(DEPTH),
    .IMPL_ADDR_W(IMPL_ADDR_W), .VECTOR(VECTOR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .lowData(lowData), .jumpField(jumpField), .latchWrite(latchWrite),
    .latchData(latchData), .progAddr(progAddr), .lowByte(lowByte)
  );

  // R7
  int_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    intEn |=> progAddr == ADDR_W'(VECTOR));

endmodule

// File: tb/paged_pc_tb.sv
module paged_pc_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic incEn = 0, lowWrite = 0, jumpEn = 0, callEn = 0, retEn = 0, intEn = 0;
  logic latchWrite = 0;
  logic [7:0]  lowData = '0;
  logic [10:0] jumpField = '0;
  logic [4:0]  latchData = '0;
  logic [12:0] progAddr, halfAddr;
  logic [7:0]  lowByte, halfLow;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_pc u_dut (
    .clk(clk), .rstN(rstN), .incEn(incEn), .lowWrite(lowWrite), .lowData(lowData),
    .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn), .intEn(intEn),
    .jumpField(jumpField), .latchWrite(latchWrite), .latchData(latchData),
    .progAddr(progAddr), .lowByte(lowByte)
  );

  paged_pc #(.IMPL_ADDR_W(12)) u_dutHalf (
    .clk(clk), .rstN(rstN), .incEn(incEn), .lowWrite(lowWrite), .lowData(lowData),
    .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn), .intEn(intEn),
    .jumpField(jumpField), .latchWrite(latchWrite), .latchData(latchData),
    .progAddr(halfAddr), .lowByte(halfLow)
  );

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    incEn = 0; lowWrite = 0; jumpEn = 0; callEn = 0; retEn = 0; intEn = 0;
    latchWrite = 0;
  endtask

  // inputs are set just after a falling edge; one rising edge later, sample at the next fall
  task automatic tick();
    @(negedge clk);
    clearIn();
  endtask

  task automatic setLatch(input logic [4:0] v);
    latchWrite = 1; latchData = v; tick();
  endtask

  task automatic writeLow(input logic [7:0] v);
    lowWrite = 1; lowData = v; tick();
  endtask

  task automatic testReset();
    check("R1 reset address", progAddr, 13'h0000);
    check("R1 reset low byte", {5'd0, lowByte}, 13'h0000);
    writeLow(8'h55);
    check("R1 holding register cleared", progAddr, 13'h0055);
  endtask

  task automatic testIncrement();
    incEn = 1; tick(); incEn = 1; tick(); incEn = 1; tick();
    check("R2 increment", progAddr, 13'h0058);
  endtask

  task automatic testLatchTiming();
    latchWrite = 1; latchData = 5'h1F; lowWrite = 1; lowData = 8'hAA; tick();
    check("R11 same-cycle write uses old latch", progAddr, 13'h00AA);
    writeLow(8'h10);
    check("R3 low write takes all latch bits", progAddr, 13'h1F10);
    check("R3 low byte readable", {5'd0, lowByte}, 13'h0010);
  endtask

  task automatic testJump();
    jumpEn = 1; jumpField = 11'h0F0; tick();
    check("R4 jump page bits", progAddr, 13'h18F0);
    setLatch(5'h07);
    jumpEn = 1; jumpField = 11'h7FF; tick();
    check("R4 latch bits 2:0 ignored", progAddr, 13'h07FF);
  endtask

  task automatic testCallReturn();
    setLatch(5'h1A);
    writeLow(8'h40);
    callEn = 1; jumpField = 11'h155; tick();
    check("R5 call target", progAddr, 13'h1955);
    retEn = 1; tick();
    check("R6 return to call plus one", progAddr, 13'h1A41);
    writeLow(8'h00);
    check("R9 latch kept across push and pop", progAddr, 13'h1A00);
  endtask

  task automatic testInterrupt();
    incEn = 1; tick();
    intEn = 1; tick();
    check("R7 interrupt vector", progAddr, 13'h0004);
    incEn = 1; tick();
    retEn = 1; tick();
    check("R7 return to interrupted address", progAddr, 13'h1A01);
  endtask

  task automatic testRing();
    logic [12:0] pushed [1:10];
    setLatch(5'h00);
    writeLow(8'h00);
    for (int i = 1; i <= 10; i++) begin
      pushed[i] = (i == 1) ? 13'h0001 : 13'(13'h100 + i);
      callEn = 1; jumpField = 11'(11'h100 + i); tick();
    end
    for (int k = 0; k < 10; k++) begin
      int idx;
      idx = (k < 8) ? 10 - k : 18 - k;
      retEn = 1; tick();
      check($sformatf("R8 ring pop %0d", k), progAddr, pushed[idx]);
    end
  endtask

  task automatic testPriority();
    logic [12:0] start;
    setLatch(5'h00);
    writeLow(8'h20);
    start = 13'h0020;
    intEn = 1; callEn = 1; jumpEn = 1; retEn = 1; lowWrite = 1; incEn = 1;
    jumpField = 11'h123; lowData = 8'h99; tick();
    check("R10 interrupt wins", progAddr, 13'h0004);
    retEn = 1; tick();
    check("R10 interrupt pushed once", progAddr, start);
    callEn = 1; jumpEn = 1; retEn = 1; lowWrite = 1; incEn = 1;
    jumpField = 11'h123; tick();
    check("R10 call over jump and return", progAddr, 13'h0123);
    retEn = 1; tick();
    check("R10 call pushed", progAddr, start + 13'd1);
    jumpEn = 1; retEn = 1; lowWrite = 1; incEn = 1; jumpField = 11'h345; tick();
    check("R10 jump over return", progAddr, 13'h0345);
    lowWrite = 1; incEn = 1; lowData = 8'h77; tick();
    check("R10 low write over increment", progAddr, 13'h0077);
  endtask

  task automatic testWrap();
    setLatch(5'h0F);
    writeLow(8'hFF);
    incEn = 1; tick();
    check("R2 full width passes 0FFFh", progAddr, 13'h1000);
    check("R2 half size wraps to 0", halfAddr, 13'h0000);
    setLatch(5'h1F);
    writeLow(8'hFF);
    incEn = 1; tick();
    check("R2 counter wraps from 1FFFh", progAddr, 13'h0000);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testIncrement();
    testLatchTiming();
    testJump();
    testCallReturn();
    testInterrupt();
    testRing();
    testPriority();
    testWrap();
    finish();
  end
endmodule